// File: doc/BRIEF.md
# Reserved Opcode NOP Sequencer

This block sits beside the instruction decoder of an enhanced 8-bit processor core and takes over every opcode that the instruction set leaves undefined. It carries each such opcode out as a no-operation. Each one uses its own byte length, its own cycle count and its own pattern of throw-away memory reads, so that bus activity and program flow look as they would on real silicon. The core raises `start` in the opcode fetch cycle with the opcode, the X register and the address of the first operand byte. The block then drives read addresses and a program-counter advance strobe, keeps `busy` high, and pulses `done` in the last cycle. The core fetches its next opcode in the cycle after `done`.

The opcodes that the block does not run are sent back to the core at once. Documented instructions raise `not_mine`. The wait and stop opcodes, and also the bit-set/clear and branch-on-bit columns when the build selects the newer instruction variant, raise `handoff` together with their byte length. The parameter `NEW_VARIANT` chooses the variant. When it is 0, the x7 and xF columns run here as one-cycle no-operations.

For opcode $5C the block has no standard addressing mode to follow. It fetches two operand bytes and then reads five times from the address made of the first operand byte as low byte and $FF as high byte.

Top module: `rsvd_nop_seq`

## Requirements
- R1: After reset, and in any cycle with no instruction in progress and `start` low, every output is 0 and `addr` is 0.
- R2: Opcodes with low nibble 3, and opcodes with low nibble B other than $CB and $DB, pulse `done` in the `start` cycle itself, with `busy`, `rd_en` and `pc_inc` low.
- R3: Opcodes $02, $22, $42, $62, $82, $C2 and $E2 take 2 cycles. Cycle 2 reads the operand at the `pc` value given with `start`, pulses `pc_inc` and pulses `done`.
- R4: Opcode $44 takes 3 cycles. Cycle 2 fetches the operand at `pc` with `pc_inc`. Cycle 3 reads address {$00, operand} and pulses `done`.
- R5: Opcodes $54, $D4 and $F4 take 4 cycles. Cycle 2 fetches the operand with `pc_inc`. Cycle 3 reads {$00, operand}. Cycle 4 reads {$00, (operand + X) mod 256} and pulses `done`.
- R6: Opcodes $DC and $FC take 4 cycles. Cycles 2 and 3 read `pc` and `pc`+1 (mod 65536), each with `pc_inc`. Cycle 4 reads {second byte, first byte} and pulses `done`.
- R7: Opcode $5C takes 8 cycles. Cycles 2 and 3 fetch two operand bytes as in R6. Cycles 4 to 8 each read {$FF, first byte}. `done` pulses in cycle 8.
- R8: For every multi-cycle opcode, `busy` is high from the `start` cycle through the `done` cycle. No read happens in the `start` cycle. `pc_inc` pulses exactly once per operand byte, always together with `rd_en`. `done` is high for one cycle only.
- R9: With `NEW_VARIANT`=1, opcodes with low nibble 7 raise `handoff` with `hand_len`=2, and low nibble F raises `handoff` with `hand_len`=3, for one cycle, with no `done`. With `NEW_VARIANT`=0 these opcodes behave as in R2.
- R10: Opcodes $CB and $DB raise `handoff` with `hand_len`=1 for one cycle in both variants, with no `done`.
- R11: Any other opcode raises `not_mine` in the `start` cycle only, and every other output stays idle.
- R12: A `start` that arrives while an instruction is in progress is ignored. The running sequence goes on unchanged, and neither `not_mine` nor an extra `done` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opcode fetch cycle: opcode, X and pc are valid |
| opcode | input | 8 | Fetched opcode |
| x_reg | input | 8 | X register value, captured at start |
| pc | input | 16 | Address of the first operand byte, captured at start |
| rdata | input | 8 | Memory read data for the current `addr` |
| rd_en | output | 1 | Memory read request |
| addr | output | 16 | Read address, 0 when `rd_en` is low |
| pc_inc | output | 1 | Advance program counter by one operand byte |
| busy | output | 1 | Reserved opcode in progress |
| done | output | 1 | Final cycle of a handled opcode |
| handoff | output | 1 | Opcode belongs to the core's extended instruction logic |
| hand_len | output | 2 | Byte length of the handed-off opcode, 0 otherwise |
| not_mine | output | 1 | Opcode is not reserved; the core decodes it |

## Verification
Two pairs of events can share a cycle. In one, the last operand fetch, its `pc_inc` and the `done` pulse coincide, which happens in cycle 2 of the two-byte opcodes. In the other, a new `start` arrives while a sequence is still running. The bench issues opcodes back to back, so one opcode's `start` follows the previous `done` by exactly one cycle. It also drives an extra `start` carrying a one-cycle opcode or a documented opcode into cycle 2 of a long sequence. The scoreboard expects the same trace it would expect with no intruder: no `done` and no `not_mine` early.

// File: rtl/rsvd_nop_pkg.sv
package rsvd_nop_pkg;

   // kind of work one opcode asks of the sequencer
   typedef enum logic [2:0] {
      K_NONE,   // not a reserved opcode
      K_ONE,    // single cycle, single byte
      K_HAND,   // passed back to the core
      K_IMM2,   // operand fetched and dropped
      K_ZP3,    // zero-page dummy read
      K_ZPX4,   // indexed zero-page dummy read
      K_ABS4,   // absolute dummy read
      K_LONG8   // two operands, five high-page reads
   } nop_kind_e;

   localparam int STEP_W = 4;

   function automatic logic [STEP_W-1:0] kind_len(nop_kind_e k);
      case (k)
         K_IMM2:  return 4'd2;
         K_ZP3:   return 4'd3;
         K_ZPX4:  return 4'd4;
         K_ABS4:  return 4'd4;
         K_LONG8: return 4'd8;
         default: return 4'd1;
      endcase
   endfunction

   function automatic logic is_multi(nop_kind_e k);
      return (k == K_IMM2) || (k == K_ZP3) || (k == K_ZPX4) ||
             (k == K_ABS4) || (k == K_LONG8);
   endfunction

endpackage

// File: rtl/rsvd_nop_decode.sv
module rsvd_nop_decode
   import rsvd_nop_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit NEW_VARIANT = 1'b1
) (
   input  logic [DATA_W-1:0] opcode,
   output nop_kind_e         kind,
   output logic [1:0]        hand_len
);

   nop_kind_e  bit_kind;
   logic [3:0] lo_nib;
   logic [3:0] hi_nib;

   assign lo_nib = opcode[3:0];
   assign hi_nib = opcode[7:4];

   // variant pick for the x7 / xF columns
   generate
      if (NEW_VARIANT) begin : g_new_cols
         assign bit_kind = K_HAND;
      end else begin : g_old_cols
         assign bit_kind = K_ONE;
      end
   endgenerate

   always_comb begin
      kind     = K_NONE;
      hand_len = 2'd0;
      case (lo_nib)
         4'h3: kind = K_ONE;
         4'hB: begin
            if (opcode == 8'hCB || opcode == 8'hDB) begin
               kind     = K_HAND;
               hand_len = 2'd1;
            end else begin
               kind = K_ONE;
            end
         end
         4'h7, 4'hF: begin
            kind = bit_kind;
            if (bit_kind == K_HAND) hand_len = (lo_nib == 4'h7) ? 2'd2 : 2'd3;
         end
         4'h2: if (!hi_nib[0] && hi_nib != 4'hA) kind = K_IMM2;
         4'h4: begin
            if (opcode == 8'h44) kind = K_ZP3;
            else if (opcode == 8'h54 || opcode == 8'hD4 || opcode == 8'hF4) kind = K_ZPX4;
         end
         4'hC: begin
            if (opcode == 8'h5C) kind = K_LONG8;
            else if (opcode == 8'hDC || opcode == 8'hFC) kind = K_ABS4;
         end
         default: kind = K_NONE;
      endcase
   end

endmodule

// File: rtl/rsvd_nop_steps.sv
module rsvd_nop_steps
   import rsvd_nop_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  nop_kind_e         kind,
   output logic              active,
   output logic              launch,
   output logic              last,
   output nop_kind_e         kind_q,
   output logic [STEP_W-1:0] step_q
);

   logic active_q;

   assign active = active_q;
   assign launch = start && !active_q && is_multi(kind);
   assign last   = active_q && (step_q == kind_len(kind_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         step_q   <= '0;
         kind_q   <= K_NONE;
      end else if (launch) begin
         active_q <= 1'b1;
         step_q   <= 4'd2;
         kind_q   <= kind;
      end else if (active_q) begin
         if (last) begin
            active_q <= 1'b0;
            step_q   <= '0;
            kind_q   <= K_NONE;
         end else begin
            step_q <= step_q + 4'd1;
         end
      end
   end

endmodule

// File: rtl/rsvd_nop_agu.sv
module rsvd_nop_agu
   import rsvd_nop_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              active,
   input  nop_kind_e         kind_q,
   input  logic [STEP_W-1:0] step_q,
   input  logic [ADDR_W-1:0] pc,
   input  logic [DATA_W-1:0] x_reg,
   input  logic [DATA_W-1:0] rdata,
   output logic              rd_en,
   output logic [ADDR_W-1:0] addr,
   output logic              pc_inc
);

   localparam int PAGE_W = ADDR_W - DATA_W;
   localparam logic [PAGE_W-1:0] PAGE_ZERO = '0;
   localparam logic [PAGE_W-1:0] PAGE_TOP  = '1;
   localparam logic [ADDR_W-1:0] ONE_A     = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic [ADDR_W-1:0] base_q;
   logic [DATA_W-1:0] x_q, lo_q, hi_q, zpx;
   logic              second_fetch;

   assign zpx          = lo_q + x_q;
   assign second_fetch = (step_q == 4'd3) && (kind_q == K_ABS4 || kind_q == K_LONG8);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         x_q    <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
      end else begin
         if (launch) begin
            base_q <= pc;
            x_q    <= x_reg;
         end
         if (active && step_q == 4'd2) lo_q <= rdata;
         if (active && second_fetch)   hi_q <= rdata;
      end
   end

   always_comb begin
      rd_en  = 1'b0;
      pc_inc = 1'b0;
      addr   = '0;
      if (active) begin
         if (step_q == 4'd2) begin
            rd_en  = 1'b1;
            pc_inc = 1'b1;
            addr   = base_q;
         end else if (second_fetch) begin
            rd_en  = 1'b1;
            pc_inc = 1'b1;
            addr   = base_q + ONE_A;
         end else begin
            case (kind_q)
               K_ZP3: begin
                  rd_en = 1'b1;
                  addr  = {PAGE_ZERO, lo_q};
               end
               K_ZPX4: begin
                  rd_en = 1'b1;
                  addr  = (step_q == 4'd4) ? {PAGE_ZERO, zpx} : {PAGE_ZERO, lo_q};
               end
               K_ABS4: begin
                  rd_en = 1'b1;
                  addr  = {hi_q, lo_q};
               end
               K_LONG8: begin
                  rd_en = 1'b1;
                  addr  = {PAGE_TOP, lo_q};
               end
               default: rd_en = 1'b0;
            endcase
         end
      end
   end

endmodule

// File: rtl/rsvd_nop_seq.sv
module rsvd_nop_seq
   import rsvd_nop_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter bit NEW_VARIANT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] opcode,
   input  logic [DATA_W-1:0] x_reg,
   input  logic [ADDR_W-1:0] pc,
   input  logic [DATA_W-1:0] rdata,
   output logic              rd_en,
   output logic [ADDR_W-1:0] addr,
   output logic              pc_inc,
   output logic              busy,
   output logic              done,
   output logic              handoff,
   output logic [1:0]        hand_len,
   output logic              not_mine
);

   if (DATA_W != 8) begin : g_bad_data_w
      $error("rsvd_nop_seq: DATA_W must be 8");
   end
   if (ADDR_W != 2 * DATA_W) begin : g_bad_addr_w
      $error("rsvd_nop_seq: ADDR_W must be twice DATA_W");
   end

   nop_kind_e         kind, kind_q;
   logic [1:0]        dec_len;
   logic              active, launch, last, fresh;
   logic [STEP_W-1:0] step_q;

   rsvd_nop_decode #(.DATA_W(DATA_W), .NEW_VARIANT(NEW_VARIANT)) i_decode (
      .opcode   (opcode),
      .kind     (kind),
      .hand_len (dec_len)
   );

   rsvd_nop_steps i_steps (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .kind   (kind),
      .active (active),
      .launch (launch),
      .last   (last),
      .kind_q (kind_q),
      .step_q (step_q)
   );

   rsvd_nop_agu #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_agu (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .active (active),
      .kind_q (kind_q),
      .step_q (step_q),
      .pc     (pc),
      .x_reg  (x_reg),
      .rdata  (rdata),
      .rd_en  (rd_en),
      .addr   (addr),
      .pc_inc (pc_inc)
   );

   // a start only counts when nothing is running
   assign fresh    = start && !active;
   assign busy     = launch || active;
   assign done     = (fresh && kind == K_ONE) || last;
   assign handoff  = fresh && (kind == K_HAND);
   assign hand_len = handoff ? dec_len : 2'd0;
   assign not_mine = fresh && (kind == K_NONE);

endmodule

// File: rtl/rsvd_nop_chk.sv
module rsvd_nop_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic              pc_inc,
   input logic              busy,
   input logic              done,
   input logic              handoff,
   input logic              not_mine
);

   p_idle_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> addr == '0);

   p_inc_with_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pc_inc |-> rd_en);

   p_read_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> busy);

   p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> busy);

   p_handoff_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
      handoff |-> !busy && !done && !rd_en && !not_mine);

   p_foreign_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
      not_mine |-> start && !busy && !done && !rd_en && !handoff);

   p_no_foreign_mid_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> !not_mine && !handoff);

endmodule

bind rsvd_nop_seq rsvd_nop_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .rd_en    (rd_en),
   .addr     (addr),
   .pc_inc   (pc_inc),
   .busy     (busy),
   .done     (done),
   .handoff  (handoff),
   .not_mine (not_mine)
);

// File: tb/test_rsvd_nop_seq.sv
module test_rsvd_nop_seq;
   timeunit 1ns;
   timeprecision 100ps;

   typedef struct packed {
      logic        rd;
      logic [15:0] addr;
      logic        inc;
      logic        busy;
      logic        done;
      logic        hand;
      logic [1:0]  hlen;
      logic        nm;
      logic        o_done;
      logic        o_hand;
      logic        o_nm;
      logic        o_busy;
   } cyc_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic [7:0]  x_reg = 8'h00;
   logic [15:0] pc = 16'h0000;
   logic [7:0]  rdata, rdata_o;
   logic        rd_en, pc_inc, busy, done, handoff, not_mine;
   logic [15:0] addr;
   logic [1:0]  hand_len;
   logic        rd_en_o, pc_inc_o, busy_o, done_o, handoff_o, not_mine_o;
   logic [15:0] addr_o;
   logic [1:0]  hand_len_o;

   int   checks = 0;
   int   fails  = 0;
   bit   mon_on = 1'b0;
   cyc_t exp_q[$];
   int   req_q[$];

   always #2 clk = ~clk;

   // memory contents are a function of the address
   function automatic logic [7:0] mem_f(input logic [15:0] a);
      return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
   endfunction

   assign rdata   = mem_f(addr);
   assign rdata_o = mem_f(addr_o);

   rsvd_nop_seq #(.NEW_VARIANT(1'b1)) i_rsvd_nop_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .x_reg(x_reg),
      .pc(pc), .rdata(rdata), .rd_en(rd_en), .addr(addr), .pc_inc(pc_inc),
      .busy(busy), .done(done), .handoff(handoff), .hand_len(hand_len),
      .not_mine(not_mine)
   );

   rsvd_nop_seq #(.NEW_VARIANT(1'b0)) i_rsvd_nop_seq_old (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .x_reg(x_reg),
      .pc(pc), .rdata(rdata_o), .rd_en(rd_en_o), .addr(addr_o), .pc_inc(pc_inc_o),
      .busy(busy_o), .done(done_o), .handoff(handoff_o), .hand_len(hand_len_o),
      .not_mine(not_mine_o)
   );

   function automatic cyc_t mk(input logic rd, input logic [15:0] a, input logic inc,
                               input logic bz, input logic dn);
      cyc_t c = '0;
      c.rd = rd; c.addr = a; c.inc = inc; c.busy = bz; c.done = dn;
      c.o_done = dn; c.o_busy = bz;
      return c;
   endfunction

   task automatic push(input cyc_t c, input int r);
      exp_q.push_back(c);
      req_q.push_back(r);
   endtask

   // expected per-cycle trace for one opcode, built from the requirements
   task automatic expect_op(input logic [7:0] op, input logic [7:0] xv, input logic [15:0] pcv);
      logic [7:0] lo, hi, idx;
      cyc_t c;
      lo  = mem_f(pcv);
      hi  = mem_f(pcv + 16'd1);
      idx = lo + xv;
      c   = '0;
      if (op[3:0] == 4'h3 || (op[3:0] == 4'hB && op != 8'hCB && op != 8'hDB)) begin
         push(mk(1'b0, 16'h0, 1'b0, 1'b0, 1'b1), 2);                  // R2
      end else if (op == 8'hCB || op == 8'hDB) begin
         c.hand = 1'b1; c.hlen = 2'd1; c.o_hand = 1'b1;
         push(c, 10);                                                  // R10
      end else if (op[3:0] == 4'h7 || op[3:0] == 4'hF) begin
         c.hand = 1'b1; c.hlen = (op[3:0] == 4'h7) ? 2'd2 : 2'd3; c.o_done = 1'b1;
         push(c, 9);                                                   // R9
      end else if (op == 8'h02 || op == 8'h22 || op == 8'h42 || op == 8'h62 ||
                   op == 8'h82 || op == 8'hC2 || op == 8'hE2) begin
         push(mk(1'b0, 16'h0, 1'b0, 1'b1, 1'b0), 8);                  // R8
         push(mk(1'b1, pcv, 1'b1, 1'b1, 1'b1), 3);                     // R3
      end else if (op == 8'h44) begin
         push(mk(1'b0, 16'h0, 1'b0, 1'b1, 1'b0), 8);
         push(mk(1'b1, pcv, 1'b1, 1'b1, 1'b0), 4);                     // R4
         push(mk(1'b1, {8'h00, lo}, 1'b0, 1'b1, 1'b1), 4);
      end else if (op == 8'h54 || op == 8'hD4 || op == 8'hF4) begin
         push(mk(1'b0, 16'h0, 1'b0, 1'b1, 1'b0), 8);
         push(mk(1'b1, pcv, 1'b1, 1'b1, 1'b0), 5);                     // R5
         push(mk(1'b1, {8'h00, lo}, 1'b0, 1'b1, 1'b0), 5);
         push(mk(1'b1, {8'h00, idx}, 1'b0, 1'b1, 1'b1), 5);
      end else if (op == 8'hDC || op == 8'hFC) begin
         push(mk(1'b0, 16'h0, 1'b0, 1'b1, 1'b0), 8);
         push(mk(1'b1, pcv, 1'b1, 1'b1, 1'b0), 6);                     // R6
         push(mk(1'b1, pcv + 16'd1, 1'b1, 1'b1, 1'b0), 6);
         push(mk(1'b1, {hi, lo}, 1'b0, 1'b1, 1'b1), 6);
      end else if (op == 8'h5C) begin
         push(mk(1'b0, 16'h0, 1'b0, 1'b1, 1'b0), 8);
         push(mk(1'b1, pcv, 1'b1, 1'b1, 1'b0), 7);                     // R7
         push(mk(1'b1, pcv + 16'd1, 1'b1, 1'b1, 1'b0), 7);
         for (int k = 0; k < 5; k++)
            push(mk(1'b1, {8'hFF, lo}, 1'b0, 1'b1, k == 4), 7);
      end else begin
         c.nm = 1'b1; c.o_nm = 1'b1;
         push(c, 11);                                                  // R11
      end
   endtask

   // driver: start in cycle 1, optional intruding start in cycle 2
   task automatic run_op(input logic [7:0] op, input logic [7:0] xv, input logic [15:0] pcv,
                         input logic [7:0] intr);
      int n;
      @(posedge clk); #1;
      start = 1'b1; opcode = op; x_reg = xv; pc = pcv;
      expect_op(op, xv, pcv);
      n = exp_q.size();
      if (intr != 8'h00 && n > 1) req_q[1] = 12;                      // R12
      for (int i = 1; i < n; i++) begin
         @(posedge clk); #1;
         start  = (i == 1) && (intr != 8'h00);
         opcode = intr;
         x_reg  = ~xv;
         pc     = ~pcv;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         start = 1'b0;
      end
   endtask

   // monitor: compare one expected cycle per falling edge, idle when empty
   always @(negedge clk) begin
      cyc_t act, ex;
      int   r;
      if (mon_on) begin
         act = {rd_en, addr, pc_inc, busy, done, handoff, hand_len, not_mine,
                done_o, handoff_o, not_mine_o, busy_o};
         if (exp_q.size() > 0) begin
            ex = exp_q.pop_front();
            r  = req_q.pop_front();
         end else begin
            ex = '0;
            r  = 1;                                                    // R1 idle
         end
         checks++;
         if (act !== ex) begin
            fails++;
            $display("FAIL R%0d t=%0t act=%h exp=%h", r, $time, act, ex);
         end
      end
   end

   initial begin
      #(200000 * 4);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;                                                        // R1 during reset
      if ({rd_en, pc_inc, busy, done, handoff, not_mine, addr} !== '0) begin
         fails++;
         $display("FAIL R1 reset act=%h exp=0", {rd_en, pc_inc, busy, done, handoff, not_mine, addr});
      end
      #1 rst_n = 1'b1;
      mon_on = 1'b1;
      idle(2);
      run_op(8'h03, 8'h00, 16'h1000, 8'h00);   // R2
      run_op(8'h7B, 8'h00, 16'h1001, 8'h00);   // R2 back to back
      run_op(8'h02, 8'h00, 16'h2345, 8'h00);   // R3
      run_op(8'hE2, 8'h00, 16'h0FFF, 8'h00);   // R3
      run_op(8'h44, 8'h00, 16'h3456, 8'h00);   // R4
      run_op(8'h54, 8'h10, 16'h4567, 8'h00);   // R5
      run_op(8'hD4, 8'hFF, 16'h5678, 8'h00);   // R5 index wraps in page zero
      run_op(8'hF4, 8'h80, 16'h00C3, 8'h00);   // R5
      run_op(8'hDC, 8'h00, 16'h6789, 8'h00);   // R6
      run_op(8'hFC, 8'h00, 16'hFFFF, 8'h00);   // R6 operand address wraps
      run_op(8'h5C, 8'h00, 16'h789A, 8'h00);   // R7
      run_op(8'h07, 8'h00, 16'h1111, 8'h00);   // R9
      run_op(8'h8F, 8'h00, 16'h1112, 8'h00);   // R9
      run_op(8'hF7, 8'h00, 16'h1113, 8'h00);   // R9
      run_op(8'hCB, 8'h00, 16'h1114, 8'h00);   // R10
      run_op(8'hDB, 8'h00, 16'h1115, 8'h00);   // R10
      run_op(8'hA9, 8'h00, 16'h1116, 8'h00);   // R11
      run_op(8'hA2, 8'h00, 16'h1117, 8'h00);   // R11
      run_op(8'h12, 8'h00, 16'h1118, 8'h00);   // R11
      run_op(8'h64, 8'h00, 16'h1119, 8'h00);   // R11
      idle(1);
      run_op(8'hDC, 8'h00, 16'h2222, 8'h03);   // R12 one-cycle intruder
      run_op(8'h44, 8'h00, 16'h3333, 8'hA9);   // R12 foreign intruder
      run_op(8'h5C, 8'h00, 16'h4444, 8'hCB);   // R12 handoff intruder
      run_op(8'h22, 8'h00, 16'h5555, 8'h00);   // R3 right after a long run
      idle(4);
      @(negedge clk);
      #1;
      if (exp_q.size() != 0) begin
         checks++;
         fails++;
         $display("FAIL R8 leftover act=%0d exp=0", exp_q.size());
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule